// File: doc/BRIEF.md
# Card Presence Detect Filter

This block watches the mechanical presence switch of each of two card slots. The raw switch level is brought into the clock domain, then read through a per-slot contact polarity. A slot's switch can be wired normally-open or normally-closed, and the bit for that slot says which. A card is only reported present or absent once the physical level has held for a fixed number of slow ticks. Contact bounce and short disturbances therefore never reach the host.

Each slot that sees a debounced presence change sets its own pending flag. The flag is set on insertion and on removal. A single interrupt line is the OR of all pending flags. The host reads the presence outputs, then clears each slot's flag with a one-cycle acknowledge. The slow tick is expected at a 1 ms rate, so the default setting of 50 ticks rejects anything shorter than 50 ms.

Top module: `slot_presence_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, `present_o`, `irq_slot_o` and `irq_o` are all zero. The filter treats each slot's switch as low and uses the normally-open reading.
- R2: With `pol_i[s]` = 0 (normally-open), a settled high switch level reports `present_o[s]` = 1. With `pol_i[s]` = 1 (normally-closed), a settled low switch level reports `present_o[s]` = 1.
- R3: A new switch level updates `present_o[s]` only on the SETTLE_TICKS-th `tick_i` pulse during which it has held (default 50). After SETTLE_TICKS-1 pulses the output is unchanged.
- R4: Any switch level change clears the slot's tick count. A level that holds for fewer than SETTLE_TICKS pulses and then reverts changes neither `present_o[s]` nor `irq_slot_o[s]`.
- R5: Only cycles with `tick_i` high advance the count. Any number of clocks without a tick leaves the output unchanged.
- R6: Each debounced presence change sets `irq_slot_o[s]`, for card insertion and for card removal alike.
- R7: `irq_slot_o[s]` stays set until a cycle with `ack_i[s]` high. It reads zero after that cycle.
- R8: When a debounced change and `ack_i[s]` occur in the same cycle, `irq_slot_o[s]` stays set.
- R9: A change of `pol_i[s]` inverts `present_o[s]` one cycle later without setting `irq_slot_o[s]`. It also clears the slot's tick count, so the pending level needs SETTLE_TICKS further pulses.
- R10: `irq_o` equals the OR of `irq_slot_o` one cycle later. The slots filter and flag independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow tick enable, one cycle wide (1 ms nominal) |
| raw_i | input | NUM_SLOTS | Raw presence switch levels, asynchronous |
| pol_i | input | NUM_SLOTS | Contact polarity per slot: 0 normally-open, 1 normally-closed |
| ack_i | input | NUM_SLOTS | Per-slot interrupt acknowledge |
| present_o | output | NUM_SLOTS | Debounced card presence per slot |
| irq_slot_o | output | NUM_SLOTS | Per-slot pending change flag |
| irq_o | output | 1 | Interrupt request, OR of pending flags |

## Verification
A tick count that is off by one shows as a presence edge one tick early or late, about four clocks away from the bench's tick pacing. The sweep over every glitch width from 1 to SETTLE_TICKS-1 catches it at once. A count that fails to restart shows as a false presence change after a long broken run of one level. Wrong flag priority, or an interrupt raised by a polarity flip, appears on `irq_slot_o` within two clocks of the triggering cycle.

// File: rtl/presence_pkg.sv
package presence_pkg;

  // Contact wiring of a slot's presence switch.
  typedef enum logic {
    POL_NORM_OPEN   = 1'b0,
    POL_NORM_CLOSED = 1'b1
  } contact_pol_e;

endpackage

// File: rtl/presence_sync.sv
module presence_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/presence_debounce.sv
module presence_debounce
  import presence_pkg::*;
#(
  parameter int SETTLE_TICKS = 50
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         lvl_i,
  input  contact_pol_e pol_i,
  output logic         present_o,
  output logic         change_o
);

  localparam int CNT_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

  logic             cand_q, cand_d;
  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  contact_pol_e     pol_q;
  logic             present_q;
  logic             upd;

  always_comb begin
    cand_d = cand_q;
    filt_d = filt_q;
    cnt_d  = cnt_q;
    upd    = 1'b0;
    if (lvl_i != cand_q) begin
      cand_d = lvl_i;
      cnt_d  = '0;
    end else if (pol_i != pol_q) begin
      cnt_d = '0;
    end else if (tick_i && (cand_q != filt_q)) begin
      if (cnt_q == LAST) begin
        filt_d = cand_q;
        cnt_d  = '0;
        upd    = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q    <= 1'b0;
      filt_q    <= 1'b0;
      cnt_q     <= '0;
      pol_q     <= POL_NORM_OPEN;
      present_q <= 1'b0;
    end else begin
      cand_q    <= cand_d;
      filt_q    <= filt_d;
      cnt_q     <= cnt_d;
      pol_q     <= pol_i;
      present_q <= filt_d ^ pol_i;
    end
  end

  assign present_o = present_q;
  assign change_o  = upd;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  assert_restart_on_change_R4: assert property (@(posedge clk) disable iff (rst)
    (lvl_i != cand_q) |=> (cnt_q == '0));

  assert_update_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> $past(tick_i));

  assert_pol_no_update_R9: assert property (@(posedge clk) disable iff (rst)
    (pol_i != pol_q) |=> $stable(filt_q));

endmodule

// File: rtl/presence_irq_flag.sv
module presence_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ack_i && !set_i) |=> flag_q);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/slot_presence_filter.sv
module slot_presence_filter
  import presence_pkg::*;
#(
  parameter int NUM_SLOTS    = 2,
  parameter int SETTLE_TICKS = 50,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [NUM_SLOTS-1:0] raw_i,
  input  logic [NUM_SLOTS-1:0] pol_i,
  input  logic [NUM_SLOTS-1:0] ack_i,
  output logic [NUM_SLOTS-1:0] present_o,
  output logic [NUM_SLOTS-1:0] irq_slot_o,
  output logic                 irq_o
);

  logic [NUM_SLOTS-1:0] lvl_sync;
  logic [NUM_SLOTS-1:0] change;
  logic [NUM_SLOTS-1:0] flags;
  logic                 irq_q;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      presence_sync #(
        .STAGES(SYNC_STAGES)
      ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_i[s]),
        .q_o (lvl_sync[s])
      );

      presence_debounce #(
        .SETTLE_TICKS(SETTLE_TICKS)
      ) u_deb (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .lvl_i     (lvl_sync[s]),
        .pol_i     (contact_pol_e'(pol_i[s])),
        .present_o (present_o[s]),
        .change_o  (change[s])
      );

      presence_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (change[s]),
        .ack_i  (ack_i[s]),
        .flag_o (flags[s])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |flags;
  end

  assign irq_slot_o = flags;
  assign irq_o      = irq_q;

  assert_irq_or_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|flags)));

endmodule

// File: tb/slot_presence_filter_bench.sv
`timescale 1ns/1ps
module slot_presence_filter_bench;

  localparam int N      = 2;
  localparam int SETTLE = 50;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic [N-1:0] raw = '0;
  logic [N-1:0] pol = '0;
  logic [N-1:0] ack = '0;
  logic [N-1:0] present;
  logic [N-1:0] irq_slot;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slot_presence_filter #(
    .NUM_SLOTS(N), .SETTLE_TICKS(SETTLE), .SYNC_STAGES(2)
  ) u_slot_presence_filter (
    .clk(clk), .rst(rst), .tick_i(tick), .raw_i(raw), .pol_i(pol),
    .ack_i(ack), .present_o(present), .irq_slot_o(irq_slot), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic set_raw(input int s, input logic v);
    raw[s] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_slot(input int s);
    ack[s] = 1'b1;
    @(negedge clk);
    ack[s] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 present in reset", 8'(present), 8'h0);
    check("R1 irq in reset", 8'({irq_slot, irq}), 8'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 8'({present, irq_slot, irq}), 8'h0);

    // Insertion on slot 0, normally-open
    set_raw(0, 1'b1);
    tick_n(SETTLE - 1);
    check("R3 no update one tick short", 8'(present), 8'h0);
    check("R3 no flag one tick short", 8'(irq_slot), 8'h0);
    tick_n(1);
    check("R2 R3 slot0 present NO high", 8'(present), 8'h1);
    check("R6 insertion flag", 8'(irq_slot), 8'h1);
    check("R10 irq OR", 8'(irq), 8'h1);

    ack_slot(0);
    check("R7 ack clears flag", 8'(irq_slot), 8'h0);
    check("R10 irq low after ack", 8'(irq), 8'h0);

    // Removal: clocks without ticks, then a broken run
    raw[0] = 1'b0;
    repeat (300) @(negedge clk);
    check("R5 no ticks no change", 8'(present), 8'h1);
    tick_n(30);
    set_raw(0, 1'b1);
    set_raw(0, 1'b0);
    tick_n(SETTLE - 1);
    check("R4 restart after level change", 8'(present), 8'h1);
    check("R7 flag stays clear", 8'(irq_slot), 8'h0);
    tick_n(1);
    check("R6 removal present", 8'(present), 8'h0);
    check("R6 removal flag", 8'(irq_slot), 8'h1);
    repeat (5) @(negedge clk);
    check("R7 flag held without ack", 8'(irq_slot), 8'h1);

    // Change coincident with ack
    set_raw(0, 1'b1);
    tick_n(SETTLE - 1);
    tick = 1'b1;
    ack[0] = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    ack[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 present after coincident change", 8'(present), 8'h1);
    check("R8 set wins over ack", 8'(irq_slot), 8'h1);
    ack_slot(0);
    check("R7 cleared", 8'(irq_slot), 8'h0);

    // Glitch sweep on slot 1 (normally-open, idle low)
    for (int w = 1; w < SETTLE; w++) begin
      set_raw(1, 1'b1);
      tick_n(w);
      set_raw(1, 1'b0);
      tick_n(2);
      check($sformatf("R4 glitch width %0d present", w), 8'(present[1]), 8'h0);
      check($sformatf("R4 glitch width %0d flag", w), 8'(irq_slot[1]), 8'h0);
    end

    // Slot 1 normally-closed
    pol[1] = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 R2 NC low reads present", 8'(present[1]), 8'h1);
    check("R9 no flag on polarity change", 8'(irq_slot), 8'h0);
    set_raw(1, 1'b1);
    tick_n(SETTLE);
    check("R2 NC high reads absent", 8'(present[1]), 8'h0);
    check("R6 slot1 flag", 8'(irq_slot), 8'h2);
    check("R10 irq from slot1 only", 8'(irq), 8'h1);
    check("R10 slot0 unaffected", 8'(present[0]), 8'h1);
    ack_slot(1);
    check("R10 irq clear", 8'({irq_slot, irq}), 8'h0);

    set_raw(1, 1'b0);
    tick_n(30);
    pol[1] = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 flip to NO inverts present", 8'(present[1]), 8'h1);
    check("R9 flip no flag", 8'(irq_slot), 8'h0);
    pol[1] = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 flip back", 8'(present[1]), 8'h0);
    tick_n(SETTLE - 1);
    check("R9 count restarted by polarity", 8'(present[1]), 8'h0);
    check("R9 no early flag", 8'(irq_slot), 8'h0);
    tick_n(1);
    check("R9 settles after full run", 8'(present[1]), 8'h1);
    check("R6 flag after settle", 8'(irq_slot), 8'h2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule